// File: doc/BRIEF.md
# Split-Phase Register File with Same-Cycle Write Bypass

This block is the architectural register file of a five-stage in-order pipeline. It holds 32 words of 32 bits. The decode stage reads it through two independent combinational read ports. The writeback stage writes it through a single port, and the stored value changes on the rising clock edge.

Some pipelines split the cycle so that the register file is written in the first half and read in the second half. This block gives the same result with a single clock edge. When the writeback stage writes a register in the same cycle that decode reads that register, the read port returns the incoming write data instead of the stale stored word. An instruction three positions behind its producer therefore gets the fresh operand with no stall.

Register 0 is hard-wired to zero. Writes to it are discarded, and it never takes the bypass path. While the synchronous active-low reset is asserted, writes are discarded and do not bypass. Reset does not clear the stored words.

Top module: `rf_split_phase`

## Requirements
- R1: A word written with `wr_en`=1 to a nonzero address is stored at the rising edge. Later reads of that address on either port return it until the address is written again.
- R2: While `wr_en`=1, `rst_n`=1 and `wr_addr` is nonzero and equal to a port's read address, that port's read data equals `wr_data` in the same cycle, before the edge.
- R3: The two read ports are independent. Any pair of addresses, including the same address on both ports, reads correctly, and both ports may bypass in the same cycle.
- R4: Address 0 always reads as 0 on both ports. A write to address 0 stores nothing and is never bypassed.
- R5: With `wr_en`=0, no stored word changes and no read port shows `wr_data`.
- R6: While `rst_n`=0, a write stores nothing and is not bypassed. Stored words keep their values across reset.
- R7: A write changes only the addressed register. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the write takes effect on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset; blocks writes while low |
| rd_addr_a | input | 5 | Read address, port A |
| rd_addr_b | input | 5 | Read address, port B |
| rd_data_a | output | 32 | Combinational read data, port A |
| rd_data_b | output | 32 | Combinational read data, port B |
| wr_en | input | 1 | Write enable from writeback |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |

## Verification
The assertions check three things on every cycle.
- Each port reads zero at address 0.
- Each port shows `wr_data` whenever it reads the register being written.
- The cycle after a write, a port reading that register returns the written word, unless a newer write to it is already under way.

Some behaviour appears only in the bench's scenarios:
- Reset does not clear the stored words, and writes made during reset are dropped.
- A disabled write leaves everything unchanged.
- A write leaves every other register untouched.

The bench shows these with full sweeps of all address pairs after known fills.

// File: rtl/rf_pkg.sv
// Package rf_pkg: shared sizes and types for the split-phase register file.
// Assumes a power-of-two register count with entry 0 hard-wired to zero.
package rf_pkg;
    parameter int unsigned RF_DEPTH = 32;
    parameter int unsigned RF_WIDTH = 32;
    parameter int unsigned RF_NRD   = 2;
    localparam int unsigned RF_AW   = $clog2(RF_DEPTH);

    typedef logic [RF_AW-1:0]    rf_addr_t;
    typedef logic [RF_WIDTH-1:0] rf_word_t;

    // Qualified write request as seen by storage and bypass logic
    typedef struct packed {
        logic     valid;
        rf_addr_t addr;
        rf_word_t data;
    } rf_wr_t;
endpackage

// File: rtl/rf_write_qual.sv
// Module rf_write_qual: turns the raw writeback request into a qualified write.
// A write is valid only when enabled, out of reset and aimed at a nonzero entry.
// Assumes rst_n is synchronous to clk.
module rf_write_qual
    import rf_pkg::*;
(
    input  logic     rst_n,
    input  logic     wr_en,
    input  rf_addr_t wr_addr,
    input  rf_word_t wr_data,
    output rf_wr_t   wr_q
);
    // Gate the request with reset and the zero-register rule
    always_comb begin
        wr_q.valid = wr_en && rst_n && (wr_addr != '0);
        wr_q.addr  = wr_addr;
        wr_q.data  = wr_data;
    end
endmodule

// File: rtl/rf_store.sv
// Module rf_store: the storage array, one flop word per nonzero entry.
// Entry 0 has no flops and reads as zero. Contents are not reset.
// Assumes wr_q.valid is never set for entry 0.
module rf_store
    import rf_pkg::*;
(
    input  logic     clk,
    input  rf_wr_t   wr_q,
    output rf_word_t words [RF_DEPTH]
);
    assign words[0] = '0;

    for (genvar i = 1; i < RF_DEPTH; i++) begin : g_entry
        rf_word_t word_r;
        // Capture write data into this entry when it is addressed
        always_ff @(posedge clk) begin
            if (wr_q.valid && wr_q.addr == rf_addr_t'(i)) begin
                word_r <= wr_q.data;
            end
        end
        assign words[i] = word_r;
    end
endmodule

// File: rtl/rf_read_port.sv
// Module rf_read_port: one combinational read port with same-cycle bypass.
// A qualified write to the read address overrides the stored word.
// Address 0 always reads as zero.
module rf_read_port
    import rf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  rf_addr_t rd_addr,
    input  rf_word_t words [RF_DEPTH],
    input  rf_wr_t   wr_q,
    output rf_word_t rd_data
);
    // Pick zero, the in-flight write, or the stored word
    always_comb begin
        if (rd_addr == '0) begin
            rd_data = '0;
        end else if (wr_q.valid && wr_q.addr == rd_addr) begin
            rd_data = wr_q.data;
        end else begin
            rd_data = words[rd_addr];
        end
    end

    // R4: register 0 is observed as zero on this port
    p_zero_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == '0) |-> (rd_data == '0));
endmodule

// File: rtl/rf_split_phase.sv
// Module rf_split_phase: 2-read, 1-write register file for a decode stage.
// A read of the register being written in the same cycle returns the new data.
// This emulates a write-first, read-second split cycle on a single clock edge.
// Assumes one writer (writeback) and synchronous active-low reset.
module rf_split_phase
    import rf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  rf_addr_t rd_addr_a,
    input  rf_addr_t rd_addr_b,
    output rf_word_t rd_data_a,
    output rf_word_t rd_data_b,
    input  logic     wr_en,
    input  rf_addr_t wr_addr,
    input  rf_word_t wr_data
);
    rf_wr_t   wr_q;
    rf_word_t words   [RF_DEPTH];
    rf_addr_t rd_addr_v [RF_NRD];
    rf_word_t rd_data_v [RF_NRD];

    rf_write_qual u_qual (
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_q    (wr_q)
    );

    rf_store u_store (
        .clk   (clk),
        .wr_q  (wr_q),
        .words (words)
    );

    assign rd_addr_v[0] = rd_addr_a;
    assign rd_addr_v[1] = rd_addr_b;

    for (genvar p = 0; p < RF_NRD; p++) begin : g_port
        rf_read_port u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_addr (rd_addr_v[p]),
            .words   (words),
            .wr_q    (wr_q),
            .rd_data (rd_data_v[p])
        );
    end

    assign rd_data_a = rd_data_v[0];
    assign rd_data_b = rd_data_v[1];

    // R2/R3: a port reading the register being written sees the new data
    p_bypass_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0 && rd_addr_a == wr_addr) |-> (rd_data_a == wr_data));
    p_bypass_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0 && rd_addr_b == wr_addr) |-> (rd_data_b == wr_data));

    // R1: the written word is held for the following read
    p_hold_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0) |=>
        ((rd_addr_a != $past(wr_addr)) || (wr_en && wr_addr == rd_addr_a)
         || (rd_data_a == $past(wr_data))));
    p_hold_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0) |=>
        ((rd_addr_b != $past(wr_addr)) || (wr_en && wr_addr == rd_addr_b)
         || (rd_data_b == $past(wr_data))));
endmodule

// File: tb/rf_split_phase_tb.sv
module rf_split_phase_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [31:0] rd_data_a, rd_data_b, wr_data = '0;
    logic        wr_en = 1'b0;
    int          total = 0, bad = 0;
    bit          done = 1'b0;
    logic [31:0] model [32];

    always #2.5 clk = ~clk;

    rf_split_phase u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic logic [31:0] pat(input int idx, input int round);
        return (32'(idx) * 32'h9E3779B1) ^ (32'(round) << 8) ^ 32'h5A5A0000;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // Drive after the falling edge, then let combinational reads settle
    task automatic drive(input logic we, input logic [4:0] wa, input logic [31:0] wd,
                         input logic [4:0] ra, input logic [4:0] rb);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr_a = ra; rd_addr_b = rb;
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Reset state: register 0 on both ports (R4)
        drive(0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        #1;
        check("R4 reset a", rd_data_a, 0);
        check("R4 reset b", rd_data_b, 0);
        rst_n = 1'b1;
        model[0] = '0;

        // Fill with bypass checks (R2, R1)
        for (int i = 1; i < 32; i++) begin
            drive(1, 5'(i), pat(i, 0), 5'(i), 5'(i - 1));
            check("R2 fill bypass a", rd_data_a, pat(i, 0));
            check("R1 fill prior b", rd_data_b, (i == 1) ? 32'h0 : model[i - 1]);
            model[i] = pat(i, 0);
        end
        drive(0, 0, 0, 0, 0);

        // All address pairs (R1, R3)
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                drive(0, 0, 32'hDEADBEEF, 5'(a), 5'(b));
                check("R3 pair a", rd_data_a, model[a]);
                check("R3 pair b", rd_data_b, model[b]);
            end
        end

        // Write to register 0 (R4)
        drive(1, 0, 32'hFFFFFFFF, 0, 0);
        check("R4 w0 bypass a", rd_data_a, 0);
        check("R4 w0 bypass b", rd_data_b, 0);
        drive(0, 0, 0, 0, 0);
        check("R4 w0 after", rd_data_a, 0);

        // Disabled write (R5)
        drive(0, 7, 32'h12345678, 7, 7);
        check("R5 no bypass a", rd_data_a, model[7]);
        check("R5 no bypass b", rd_data_b, model[7]);
        drive(0, 0, 0, 7, 7);
        check("R5 no store", rd_data_a, model[7]);

        // Both ports bypass the same register (R3)
        drive(1, 12, pat(12, 1), 12, 12);
        check("R3 dual bypass a", rd_data_a, pat(12, 1));
        check("R3 dual bypass b", rd_data_b, pat(12, 1));
        model[12] = pat(12, 1);
        drive(0, 0, 0, 12, 11);
        check("R1 stored after bypass", rd_data_a, model[12]);
        check("R7 neighbour", rd_data_b, model[11]);

        // Write during reset (R6)
        @(negedge clk); rst_n = 1'b0;
        drive(1, 9, 32'hCAFEF00D, 9, 10);
        check("R6 no bypass in reset", rd_data_a, model[9]);
        drive(0, 0, 0, 9, 10);
        rst_n = 1'b1;
        #1;
        check("R6 not stored", rd_data_a, model[9]);
        check("R6 kept over reset", rd_data_b, model[10]);

        // Single overwrite, sweep others (R7)
        drive(1, 16, pat(16, 2), 0, 0);
        model[16] = pat(16, 2);
        for (int i = 0; i < 32; i++) begin
            drive(0, 0, 0, 5'(i), 5'(31 - i));
            check("R7 sweep a", rd_data_a, model[i]);
            check("R7 sweep b", rd_data_b, model[31 - i]);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule